// File: doc/BRIEF.md
# Three-Wire Addressed Dual-Loop Control Port

This block is the serial control front end of a dual frequency-synthesiser chip. A host shifts a word in, most significant bit first, on a serial clock and data pair while a select line is held high. When the select line falls, the block looks at the bit that arrived last. That bit is an address and picks which of two configuration registers takes the word. To configure both loops, the host sends two separate words, one per loop.

The first loop's register holds a 15-bit divider value, a 2-bit pump-current code, a 3-bit reference-ratio code and the two switch-port bits. The second loop's register holds a 16-bit divider value, a 1-bit pump-current code, a 3-bit reference-ratio code and a 3-bit test field. The host may leave off the top two test bits, so the second loop's word can be 22, 23 or 24 bits long. Missing bits read as zero.

Two open-drain switch ports normally follow the port bits. When the test field enables a test mode, they instead carry comparison strobes or halved divider strobes. In some test modes the block also raises pump override lines. The serial lines are oversampled by the block's own clock, which must run well above the serial clock rate.

Top module: `tw_ctrl_top`

## Requirements
- R1: After reset, every configuration field is zero, neither switch port sinks, and no pump override line is raised.
- R2: A word whose last bit is 0 and that has at least 23 bits loads the first loop's register from the last 23 bits. Bit positions count from the address bit 0: [22] port 1, [21] port 0, [20:19] pump code, [18:16] reference code, [15:1] divider value. The second loop's register is unchanged.
- R3: A word whose last bit is 1 and that has 24 bits loads the second loop's register. Bit positions: [23:21] test field {T2,T1,T0}, [20] pump code, [19:17] reference code, [16:1] divider value. The first loop's register is unchanged.
- R4: A second-loop word of 22 or 23 bits is accepted, and every test bit above the received length is loaded as 0.
- R5: A word is discarded, and no register changes, if its address is 0 and it has fewer than 23 bits, or if its address is 1 and it has fewer than 22 bits.
- R6: Serial clock edges are ignored while the select line is low. This includes a rising clock edge seen in the same sampled cycle as the select line's fall.
- R7: A word longer than 24 bits is decoded from its last 24 bits only.
- R8: When T0 is 0, each switch port sinks (port_sink bit = 1) exactly when its port bit is 1. Index 1 is port 1 and index 0 is port 0. All pump override lines stay low.
- R9: Test field 001 raises pump_sink only. Test field 011 raises pump_source only. In both, the ports still follow the port bits.
- R10: Test field 101 raises pump_off. Port 1 follows the first loop's comparison input and port 0 follows the second loop's comparison input.
- R11: Test field 111 drives port 1 and port 0 from toggle flops. Each flop flips once per clock cycle in which its loop's divider strobe is high, and clears at reset.
- R12: A configuration register changes only after the select line falls. While a word is still being shifted in, the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Select line, high during a word |
| cmp1_in | input | 1 | First loop comparison strobe |
| cmp2_in | input | 1 | Second loop comparison strobe |
| div1_in | input | 1 | First loop divider strobe, one clk cycle per pulse |
| div2_in | input | 1 | Second loop divider strobe, one clk cycle per pulse |
| l1_freq | output | 15 | First loop divider value |
| l1_pump | output | 2 | First loop pump-current code |
| l1_ref | output | 3 | First loop reference-ratio code |
| l2_freq | output | 16 | Second loop divider value |
| l2_pump | output | 1 | Second loop pump-current code |
| l2_ref | output | 3 | Second loop reference-ratio code |
| port_sink | output | 2 | Open-drain switch ports, 1 = sink |
| pump_sink | output | 1 | Test override: both pumps sink |
| pump_source | output | 1 | Test override: both pumps source |
| pump_off | output | 1 | Test override: both pumps disabled |

## Verification
Two events can land in the same sampled cycle: a rising edge of the serial clock and the fall of the select line. The bench provokes this by moving both lines at the same instant on the last bit of a first-loop word. Both lines pass through identical synchronisers, so the block sees both events in one cycle. The correct outcome is that the final bit is not taken. The word then counts as 22 bits with an address 0 and must be discarded, so every output must keep its earlier value. A second overlap is a divider strobe arriving while a new word changes the test mode. The bench tracks the toggle flops' parity across all modes, so the halved ports are checked against every pulse sent since reset.

// File: rtl/tw_pkg.sv
// Shared widths, field layouts and test-mode codes for the three-wire
// control port. Field order inside each struct follows the order the
// bits arrive on the wire, so a struct is loaded straight from the
// shift register.
package tw_pkg;
    localparam int L1_FREQ_W = 15;
    localparam int L2_FREQ_W = 16;
    localparam int L1_CP_W   = 2;
    localparam int REF_W     = 3;
    localparam int PORT_W    = 2;
    localparam int TEST_W    = 3;

    // Word lengths including the address bit.
    localparam int L1_LEN  = PORT_W + L1_CP_W + REF_W + L1_FREQ_W + 1;
    localparam int L2_LEN  = TEST_W + 1 + REF_W + L2_FREQ_W + 1;
    localparam int L2_MIN  = L2_LEN - (TEST_W - 1);
    localparam int SHIFT_W = (L2_LEN > L1_LEN) ? L2_LEN : L1_LEN;
    localparam int CNT_W   = $clog2(SHIFT_W) + 1;

    typedef struct packed {
        logic [PORT_W-1:0]    port;
        logic [L1_CP_W-1:0]   pump;
        logic [REF_W-1:0]     ref_sel;
        logic [L1_FREQ_W-1:0] freq;
    } l1_cfg_t;

    typedef struct packed {
        logic [TEST_W-1:0]    test;
        logic                 pump;
        logic [REF_W-1:0]     ref_sel;
        logic [L2_FREQ_W-1:0] freq;
    } l2_cfg_t;

    // Upper two test bits, meaningful only when the lowest test bit is 1.
    typedef enum logic [1:0] {
        TM_SINK    = 2'b00,
        TM_SOURCE  = 2'b01,
        TM_COMPARE = 2'b10,
        TM_HALVE   = 2'b11
    } test_sel_t;
endpackage

// File: rtl/tw_sync.sv
// Level synchroniser for one asynchronous serial line.
// Assumes STAGES >= 2; all three bus lines use the same depth so their
// relative timing is preserved.
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/tw_shift_rx.sv
// Serial receiver: shifts bits on sampled clock rises while select is high,
// counts them, and on the select fall presents the right-aligned word with
// a valid strobe if the length suits the address bit.
// Assumes inputs are already synchronised to clk.
module tw_shift_rx
    import tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_lvl,
    input  logic               sdata_lvl,
    input  logic               en_lvl,
    output logic               load_vld,
    output logic [SHIFT_W-1:0] load_word
);
    logic [SHIFT_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_last;
    logic               en_last;
    logic               sclk_rise;
    logic               en_fall;
    logic               len_ok;

    assign sclk_rise = sclk_lvl & ~sclk_last;
    assign en_fall   = ~en_lvl & en_last;

    // Length rule: address 1 words may omit the two upper test bits.
    always_comb begin
        if (shreg[0]) len_ok = (cnt >= CNT_W'(L2_MIN));
        else          len_ok = (cnt >= CNT_W'(L1_LEN));
    end

    // Edge history of the sampled clock and select lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_last <= 1'b0;
            en_last   <= 1'b0;
        end else begin
            sclk_last <= sclk_lvl;
            en_last   <= en_lvl;
        end
    end

    // Shift, count and hand over the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            load_vld  <= 1'b0;
            load_word <= '0;
        end else begin
            load_vld <= 1'b0;
            if (en_fall) begin
                load_word <= shreg;
                load_vld  <= len_ok;
            end
            if (!en_lvl) begin
                shreg <= '0;
                cnt   <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[SHIFT_W-2:0], sdata_lvl};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end
    end

    // R12: a word is handed over only in the cycle after select was seen low.
    a_r12_load_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |-> !$past(en_lvl));
endmodule

// File: rtl/tw_cfg_regs.sv
// The two loop configuration registers. The address bit of a valid word
// picks which one loads; the other holds.
// Assumes load_word is right-aligned with bits above the length cleared.
module tw_cfg_regs
    import tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_vld,
    input  logic [SHIFT_W-1:0] load_word,
    output l1_cfg_t            l1,
    output l2_cfg_t            l2
);
    // First loop register, address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                        l1 <= '0;
        else if (load_vld && !load_word[0]) l1 <= l1_cfg_t'(load_word[L1_LEN-1:1]);
    end

    // Second loop register, address 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                       l2 <= '0;
        else if (load_vld && load_word[0]) l2 <= l2_cfg_t'(load_word[L2_LEN-1:1]);
    end

    // R2: the first loop register holds unless an address-0 word arrives.
    a_r2_l1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_vld && !load_word[0]) |=> $stable(l1));
    // R3: the second loop register holds unless an address-1 word arrives.
    a_r3_l2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_vld && load_word[0]) |=> $stable(l2));
    // R3: one word never changes both registers.
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> !((l1 != $past(l1)) && (l2 != $past(l2))));
endmodule

// File: rtl/tw_port_mux.sv
// Switch-port and pump-override logic: ports follow their register bits
// in normal operation and carry test strobes in the test modes.
// Assumes cmp and div strobes are synchronous to clk; a div strobe lasts
// one cycle per pulse.
module tw_port_mux
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_bits,
    input  logic [TEST_W-1:0] test,
    input  logic [PORT_W-1:0] cmp,
    input  logic [PORT_W-1:0] div,
    output logic [PORT_W-1:0] port_sink,
    output logic              pump_sink,
    output logic              pump_source,
    output logic              pump_off
);
    logic [PORT_W-1:0] half;
    test_sel_t         sel;

    assign sel = test_sel_t'(test[2:1]);

    for (genvar g = 0; g < PORT_W; g++) begin : g_half
        // Divide one loop's divider strobe by two.
        always_ff @(posedge clk) begin
            if (!rst_n)      half[g] <= 1'b0;
            else if (div[g]) half[g] <= ~half[g];
        end

        // R11: the flop flips after each strobe and holds otherwise.
        a_r11_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            div[g] |=> (half[g] != $past(half[g])));
        a_r11_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !div[g] |=> $stable(half[g]));
    end

    // Select port sources and pump overrides from the test field.
    always_comb begin
        port_sink   = port_bits;
        pump_sink   = 1'b0;
        pump_source = 1'b0;
        pump_off    = 1'b0;
        if (test[0]) begin
            unique case (sel)
                TM_SINK:    pump_sink   = 1'b1;
                TM_SOURCE:  pump_source = 1'b1;
                TM_COMPARE: begin
                    pump_off  = 1'b1;
                    port_sink = cmp;
                end
                TM_HALVE:   port_sink = half;
            endcase
        end
    end

    // R9: at most one pump override is active.
    a_r9_override_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pump_sink, pump_source, pump_off}));
endmodule

// File: rtl/tw_ctrl_top.sv
// Three-wire addressed control port for two synthesiser loops.
// Synchronises the serial lines, receives words, loads the addressed
// register and drives the switch ports and pump overrides.
// Assumes clk runs several times faster than ser_clk.
module tw_ctrl_top
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_en,
    input  logic                 cmp1_in,
    input  logic                 cmp2_in,
    input  logic                 div1_in,
    input  logic                 div2_in,
    output logic [L1_FREQ_W-1:0] l1_freq,
    output logic [L1_CP_W-1:0]   l1_pump,
    output logic [REF_W-1:0]     l1_ref,
    output logic [L2_FREQ_W-1:0] l2_freq,
    output logic                 l2_pump,
    output logic [REF_W-1:0]     l2_ref,
    output logic [PORT_W-1:0]    port_sink,
    output logic                 pump_sink,
    output logic                 pump_source,
    output logic                 pump_off
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               load_vld;
    logic [SHIFT_W-1:0] load_word;
    l1_cfg_t            l1;
    l2_cfg_t            l2;

    assign raw_lines = {ser_en, ser_clk, ser_data};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    tw_shift_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (sync_lines[1]),
        .sdata_lvl(sync_lines[0]),
        .en_lvl   (sync_lines[2]),
        .load_vld (load_vld),
        .load_word(load_word)
    );

    tw_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_vld (load_vld),
        .load_word(load_word),
        .l1       (l1),
        .l2       (l2)
    );

    tw_port_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_bits  (l1.port),
        .test       (l2.test),
        .cmp        ({cmp1_in, cmp2_in}),
        .div        ({div1_in, div2_in}),
        .port_sink  (port_sink),
        .pump_sink  (pump_sink),
        .pump_source(pump_source),
        .pump_off   (pump_off)
    );

    assign l1_freq = l1.freq;
    assign l1_pump = l1.pump;
    assign l1_ref  = l1.ref_sel;
    assign l2_freq = l2.freq;
    assign l2_pump = l2.pump;
    assign l2_ref  = l2.ref_sel;

    // R1: the first cycle after reset shows quiet ports and no overrides.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (port_sink == '0 && !pump_sink && !pump_source && !pump_off));
endmodule

// File: tb/sim_tw_ctrl_top.sv
module sim_tw_ctrl_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // Each entry: [28:24] bit count, [23:0] word (sent from bit count-1 down to 0).
    localparam logic [28:0] VEC [NVEC] = '{
        {5'd23, 1'b0, 2'b10, 2'b01, 3'b101, 15'h1234, 1'b0},
        {5'd24, 3'b000, 1'b1, 3'b011, 16'hBEEF, 1'b1},
        {5'd22, 2'b00, 1'b0, 1'b0, 3'b110, 16'h0F0F, 1'b1},
        {5'd22, 2'b00, 22'h2AAAA8},
        {5'd21, 3'b000, 21'h1FFFFF},
        {5'd24, 3'b001, 1'b0, 3'b001, 16'h5555, 1'b1},
        {5'd24, 3'b011, 1'b1, 3'b111, 16'h0001, 1'b1},
        {5'd23, 1'b0, 2'b01, 2'b11, 3'b000, 15'h7FFF, 1'b0},
        {5'd23, 1'b0, 2'b11, 1'b0, 3'b010, 16'hA5A5, 1'b1},
        {5'd24, 3'b101, 1'b0, 3'b100, 16'h1357, 1'b1},
        {5'd24, 3'b111, 1'b1, 3'b001, 16'h2468, 1'b1},
        {5'd24, 3'b000, 1'b0, 3'b000, 16'hFFFF, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
    logic cmp1 = 1'b0, cmp2 = 1'b0, div1 = 1'b0, div2 = 1'b0;
    logic [14:0] l1_freq;
    logic [1:0]  l1_pump;
    logic [2:0]  l1_ref;
    logic [15:0] l2_freq;
    logic        l2_pump;
    logic [2:0]  l2_ref;
    logic [1:0]  port_sink;
    logic        pump_sink, pump_source, pump_off;

    int checks = 0;
    int fails = 0;

    // Model state derived from the requirements.
    logic [1:0]  m_p;
    logic [1:0]  m_cu;
    logic [2:0]  m_ru;
    logic [14:0] m_f1;
    logic [2:0]  m_t;
    logic        m_cd;
    logic [2:0]  m_rd;
    logic [15:0] m_f2;
    logic        h1, h2;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_ctrl_top u0 (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .cmp1_in(cmp1), .cmp2_in(cmp2), .div1_in(div1), .div2_in(div2),
        .l1_freq(l1_freq), .l1_pump(l1_pump), .l1_ref(l1_ref),
        .l2_freq(l2_freq), .l2_pump(l2_pump), .l2_ref(l2_ref),
        .port_sink(port_sink), .pump_sink(pump_sink),
        .pump_source(pump_source), .pump_off(pump_off)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_p = '0; m_cu = '0; m_ru = '0; m_f1 = '0;
        m_t = '0; m_cd = 1'b0; m_rd = '0; m_f2 = '0;
        h1 = 1'b0; h2 = 1'b0;
    endtask

    // Apply R2/R3/R4/R5/R7 to a word of n bits; report which rule applied.
    task automatic model_load(input logic [31:0] v, input int n, output string tag);
        logic [31:0] w;
        w = (n >= 32) ? v : (v & ((32'd1 << n) - 32'd1));
        w = w & 32'h00FF_FFFF;
        if (!w[0] && n >= 23) begin
            m_p = w[22:21]; m_cu = w[20:19]; m_ru = w[18:16]; m_f1 = w[15:1];
            tag = (n > 24) ? "R7" : "R2";
        end else if (w[0] && n >= 22) begin
            m_t = w[23:21]; m_cd = w[20]; m_rd = w[19:17]; m_f2 = w[16:1];
            tag = (n < 24) ? "R4" : "R3";
        end else begin
            tag = "R5";
        end
    endtask

    task automatic check_all(input string tag);
        logic [1:0] e_port;
        logic e_ps, e_src, e_off;
        string mtag;
        e_port = m_p; e_ps = 1'b0; e_src = 1'b0; e_off = 1'b0; mtag = "R8";
        if (m_t[0]) begin
            case (m_t[2:1])
                2'b00: begin e_ps = 1'b1; mtag = "R9"; end
                2'b01: begin e_src = 1'b1; mtag = "R9"; end
                2'b10: begin e_off = 1'b1; e_port = {cmp1, cmp2}; mtag = "R10"; end
                default: begin e_port = {h1, h2}; mtag = "R11"; end
            endcase
        end
        chk({tag, " l1_freq"}, 32'(l1_freq), 32'(m_f1));
        chk({tag, " l1_pump"}, 32'(l1_pump), 32'(m_cu));
        chk({tag, " l1_ref"},  32'(l1_ref),  32'(m_ru));
        chk({tag, " l2_freq"}, 32'(l2_freq), 32'(m_f2));
        chk({tag, " l2_pump"}, 32'(l2_pump), 32'(m_cd));
        chk({tag, " l2_ref"},  32'(l2_ref),  32'(m_rd));
        chk({tag, " ", mtag, " port_sink"}, 32'(port_sink), 32'(e_port));
        chk({tag, " ", mtag, " pump_sink"}, 32'(pump_sink), 32'(e_ps));
        chk({tag, " ", mtag, " pump_source"}, 32'(pump_source), 32'(e_src));
        chk({tag, " ", mtag, " pump_off"}, 32'(pump_off), 32'(e_off));
    endtask

    // Shift n bits MSB first; cut_last drops select together with the last clock rise.
    task automatic send_bits(input logic [31:0] v, input int n, input bit cut_last);
        ser_en = 1'b1;
        wait_clk(6);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wait_clk(4);
            ser_clk = 1'b1;
            if (i == 0 && cut_last) ser_en = 1'b0;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        if (!cut_last) begin
            wait_clk(8);
            check_all("R12 mid-word");
            ser_en = 1'b0;
        end
        wait_clk(12);
    endtask

    task automatic send_and_check(input logic [31:0] v, input int n);
        string tag;
        send_bits(v, n, 1'b0);
        model_load(v, n, tag);
        check_all(tag);
    endtask

    task automatic pulse_div(input bit which1);
        if (which1) begin div1 = 1'b1; h1 = ~h1; end
        else        begin div2 = 1'b1; h2 = ~h2; end
        wait_clk(1);
        div1 = 1'b0; div2 = 1'b0;
        wait_clk(2);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog R12 act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        string tag;
        model_reset();
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check_all("R1 reset");

        // Table walk over R2..R5 and the test modes.
        for (int k = 0; k < NVEC; k++) begin
            send_and_check(32'(VEC[k][23:0]), int'(VEC[k][28:24]));
        end

        // R6: clock edges with select low change nothing.
        ser_en = 1'b0;
        ser_data = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0;
        end
        wait_clk(10);
        check_all("R6 idle clocks");

        // R6: last clock rise coincides with select fall -> 22 bits, address 0, dropped.
        send_bits({9'd0, 1'b0, 2'b01, 2'b10, 3'b011, 15'h0AA0, 1'b0}, 23, 1'b1);
        model_load({9'd0, 1'b0, 2'b01, 2'b10, 3'b011, 15'h0AA0, 1'b0} >> 1, 22, tag);
        check_all("R6 same-cycle fall");

        // R7: over-long word, last 23 bits form a first-loop word.
        send_and_check({4'hF, 1'b1, 2'b01, 2'b10, 3'b110, 15'h2C3D, 1'b0}, 28);

        // R10: comparison mode routes strobes to the ports.
        send_and_check({8'd0, 3'b101, 1'b1, 3'b010, 16'h0033, 1'b1}, 24);
        cmp1 = 1'b1; cmp2 = 1'b0; wait_clk(3);
        check_all("R10 cmp1");
        cmp1 = 1'b0; cmp2 = 1'b1; wait_clk(3);
        check_all("R10 cmp2");
        cmp2 = 1'b0;

        // R11: halved divider strobes.
        send_and_check({8'd0, 3'b111, 1'b0, 3'b001, 16'h0044, 1'b1}, 24);
        pulse_div(1'b1); pulse_div(1'b1); pulse_div(1'b1);
        pulse_div(1'b0); pulse_div(1'b0);
        check_all("R11 halves");
        pulse_div(1'b0);
        check_all("R11 halves again");

        // R1: reset mid-run clears everything.
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        model_reset();
        wait_clk(2);
        check_all("R1 rerun reset");

        summary();
        $finish;
    end
endmodule